// File: doc/BRIEF.md
# SDRAM Command Decoder

This block watches the control pins of a synchronous DRAM and names the command on them in every clock cycle. On each rising edge it captures clock enable, chip select, the three strobes (RAS, CAS, WE, all active low) and address bit A10. It then drives a one-hot command vector and a flag for combinations that have no legal meaning. It is meant to sit beside a memory model or inside a protocol checker. It does no bank tracking and no data handling.

The decoder keeps the clock enable from the previous capture. This lets it see the four clock-enable transitions (stay high, fall, rise, stay low). The transition separates commands that share a strobe pattern. Auto refresh differs from self-refresh entry only by whether clock enable stays high or falls. An exit from power-down or self-refresh differs from a clock-suspend exit by whether the exit cycle carries an idle pattern or a real command.

Pins captured at edge k are decoded after edge k and hold until edge k+1. The previous clock enable is the one captured at edge k-1. It resets to low.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both captured clock enables are low. The output is bit 15 (hold) with the illegal flag clear.
- R2: When the illegal flag is clear, exactly one bit of `cmdOneHot` is set. When it is set, `cmdOneHot` is all zeros.
- R3: If clock enable is high in both cycles, the pattern is idle (bit 0, no-op) when either chip select is high or all three strobes are high.
- R4: If clock enable is high in both cycles and chip select is low, the strobe patterns decode as follows, and A10 is ignored for both:
  - all three strobes low (RAS/CAS/WE = 000): mode-register load, bit 1.
  - RAS low, CAS high, WE high (011): row activate, bit 2.
- R5: If clock enable is high in both cycles, RAS/CAS/WE = 101 is a read and 100 is a write. A10 chooses plain or auto-precharge:
  - read: bit 3 when A10 is low, bit 4 when A10 is high.
  - write: bit 5 when A10 is low, bit 6 when A10 is high.
- R6: If clock enable is high in both cycles, RAS/CAS/WE = 010 is a precharge. It is bit 7 (one bank) when A10 is low and bit 8 (all banks) when A10 is high.
- R7: If clock enable is high in both cycles, RAS/CAS/WE = 110 is a burst stop, bit 9.
- R8: If clock enable is high in both cycles, RAS/CAS/WE = 001 is an auto refresh, bit 10.
- R9: When clock enable falls from high to low with RAS/CAS/WE = 001 and chip select low, the output is self-refresh entry, bit 11.
- R10: When clock enable falls from high to low with an idle pattern, the output is power-down or clock-suspend entry, bit 12.
- R11: When clock enable rises from low to high, the output depends on the pattern:
  - an idle pattern gives power-down or self-refresh exit, bit 13.
  - any other pattern gives clock-suspend exit, bit 14.
- R12: When clock enable is low in both cycles, the output is hold, bit 15, whatever the other pins carry.
- R13: When clock enable falls from high to low with any pattern other than idle or refresh, the illegal flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| a10 | input | 1 | Address bit 10 (precharge qualifier) |
| cmdOneHot | output | 16 | Decoded command, one bit per command |
| illegalCmd | output | 1 | Set for an illegal combination |

## Verification
The hardest outputs to reach are those that depend on the clock-enable transition rather than on the pins of a single cycle. These are the clock-suspend exit, the illegal combination and the hold state, and each needs clock enable placed in a chosen state one cycle earlier. The stimulus walks clock enable through all four transitions. On each transition it applies the idle pattern, the refresh pattern and ordinary commands. Every decoded cycle is checked against an expected code queued by the driver.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam int CMD_COUNT = 16;
  localparam int KIND_W    = $clog2(CMD_COUNT);

  typedef enum logic [KIND_W-1:0] {
    KIND_NOP        = 4'd0,
    KIND_MODE_LOAD  = 4'd1,
    KIND_ACTIVATE   = 4'd2,
    KIND_READ       = 4'd3,
    KIND_READ_AP    = 4'd4,
    KIND_WRITE      = 4'd5,
    KIND_WRITE_AP   = 4'd6,
    KIND_PRE_ONE    = 4'd7,
    KIND_PRE_ALL    = 4'd8,
    KIND_BURST_STOP = 4'd9,
    KIND_AUTO_REF   = 4'd10,
    KIND_SELF_ENTER = 4'd11,
    KIND_SLEEP      = 4'd12,
    KIND_WAKE       = 4'd13,
    KIND_RESUME     = 4'd14,
    KIND_HOLD       = 4'd15
  } cmdKind_e;

  typedef struct packed {
    logic cke;
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
    logic a10;
  } pinSample_t;

  typedef struct packed {
    logic     valid;
    cmdKind_e kind;
    logic     illegal;
  } decodeStrobe_t;

endpackage

// File: rtl/sdram_cmd_datapath.sv
module sdram_cmd_datapath
  import sdram_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  pinSample_t           pinsIn,
  input  decodeStrobe_t        strobe,
  output pinSample_t           sample,
  output logic                 ckePrev,
  output logic [CMD_COUNT-1:0] cmdOneHot,
  output logic                 illegalCmd
);

  localparam pinSample_t RESET_SAMPLE = '{cke: 1'b0, csN: 1'b1, rasN: 1'b1,
                                          casN: 1'b1, weN: 1'b1, a10: 1'b0};

  pinSample_t sampleQ;
  logic       ckePrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleQ  <= RESET_SAMPLE;
      ckePrevQ <= 1'b0;
    end else begin
      sampleQ  <= pinsIn;
      ckePrevQ <= sampleQ.cke;
    end
  end

  assign sample  = sampleQ;
  assign ckePrev = ckePrevQ;

  for (genvar i = 0; i < CMD_COUNT; i++) begin : g_hot
    assign cmdOneHot[i] = strobe.valid && (strobe.kind == cmdKind_e'(i));
  end

  assign illegalCmd = strobe.illegal;

  // R2
  onehot_or_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !illegalCmd |-> ($countones(cmdOneHot) == 1));

  // R2
  illegal_clears_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> (cmdOneHot == '0));

  // R12
  prev_cke_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    ckePrevQ |-> $past(pinsIn.cke, 2));

endmodule

// File: rtl/sdram_cmd_control.sv
module sdram_cmd_control
  import sdram_cmd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  pinSample_t    sample,
  input  logic          ckePrev,
  output decodeStrobe_t strobe
);

  logic       isIdle;
  logic       isRefresh;
  logic [2:0] strobes;

  assign strobes   = {sample.rasN, sample.casN, sample.weN};
  assign isIdle    = sample.csN || (strobes == 3'b111);
  assign isRefresh = !sample.csN && (strobes == 3'b001);

  always_comb begin
    strobe = '{valid: 1'b1, kind: KIND_NOP, illegal: 1'b0};
    unique case ({ckePrev, sample.cke})
      2'b11: begin
        if (isIdle) begin
          strobe.kind = KIND_NOP;
        end else begin
          unique case (strobes)
            3'b000:  strobe.kind = KIND_MODE_LOAD;
            3'b011:  strobe.kind = KIND_ACTIVATE;
            3'b101:  strobe.kind = sample.a10 ? KIND_READ_AP : KIND_READ;
            3'b100:  strobe.kind = sample.a10 ? KIND_WRITE_AP : KIND_WRITE;
            3'b010:  strobe.kind = sample.a10 ? KIND_PRE_ALL : KIND_PRE_ONE;
            3'b110:  strobe.kind = KIND_BURST_STOP;
            3'b001:  strobe.kind = KIND_AUTO_REF;
            default: strobe.kind = KIND_NOP;
          endcase
        end
      end
      2'b10: begin
        if (isIdle) begin
          strobe.kind = KIND_SLEEP;
        end else if (isRefresh) begin
          strobe.kind = KIND_SELF_ENTER;
        end else begin
          strobe.valid   = 1'b0;
          strobe.illegal = 1'b1;
        end
      end
      2'b01:   strobe.kind = isIdle ? KIND_WAKE : KIND_RESUME;
      default: strobe.kind = KIND_HOLD;
    endcase
  end

  // R13
  illegal_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.illegal |-> (ckePrev && !sample.cke && !sample.csN));

  // R12
  hold_when_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ckePrev && !sample.cke) |-> (strobe.valid && strobe.kind == KIND_HOLD));

  // R8
  auto_ref_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.valid && strobe.kind == KIND_AUTO_REF) |-> (ckePrev && sample.cke));

  // R9
  self_enter_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.valid && strobe.kind == KIND_SELF_ENTER) |-> (ckePrev && !sample.cke));

endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cke,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        a10,
  output logic [15:0] cmdOneHot,
  output logic        illegalCmd
);

  pinSample_t    pinsIn;
  pinSample_t    sample;
  logic          ckePrev;
  decodeStrobe_t strobe;

  assign pinsIn = '{cke: cke, csN: csN, rasN: rasN, casN: casN, weN: weN, a10: a10};

  sdram_cmd_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .pinsIn     (pinsIn),
    .strobe     (strobe),
    .sample     (sample),
    .ckePrev    (ckePrev),
    .cmdOneHot  (cmdOneHot),
    .illegalCmd (illegalCmd)
  );

  sdram_cmd_control u_control (
    .clk     (clk),
    .rstN    (rstN),
    .sample  (sample),
    .ckePrev (ckePrev),
    .strobe  (strobe)
  );

endmodule

// File: tb/sdram_cmd_decoder_tb.sv
module sdram_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cke = 1'b0;
  logic        csN = 1'b1;
  logic        rasN = 1'b1;
  logic        casN = 1'b1;
  logic        weN = 1'b1;
  logic        a10 = 1'b0;
  logic [15:0] cmdOneHot;
  logic        illegalCmd;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  logic [15:0] expCmdQ[$];
  logic        expIllQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  sdram_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN),
    .casN(casN), .weN(weN), .a10(a10),
    .cmdOneHot(cmdOneHot), .illegalCmd(illegalCmd)
  );

  task automatic checkNow(string tag, logic [15:0] actCmd, logic actIll,
                          logic [15:0] expCmd, logic expIll);
    testsRun++;
    if (actCmd !== expCmd || actIll !== expIll) begin
      testsFailed++;
      $display("FAIL %s: cmd=%h ill=%b expected cmd=%h ill=%b",
               tag, actCmd, actIll, expCmd, expIll);
    end
  endtask

  // pins: {cs,ras,cas,we}; code <0 means illegal
  task automatic drive(string tag, logic k, logic [3:0] pins, logic addr10, int code);
    @(negedge clk);
    cke = k;
    {csN, rasN, casN, weN} = pins;
    a10 = addr10;
    expCmdQ.push_back(code < 0 ? 16'h0 : (16'h1 << code));
    expIllQ.push_back(code < 0);
    tagQ.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      if (expCmdQ.size() != 0) begin
        logic [15:0] e;
        logic        ei;
        string       t;
        e  = expCmdQ.pop_front();
        ei = expIllQ.pop_front();
        t  = tagQ.pop_front();
        checkNow(t, cmdOneHot, illegalCmd, e, ei);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  localparam logic [3:0] DESEL = 4'b1000, NOPC = 4'b0111, MRS = 4'b0000,
                         ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, BST = 4'b0110, REF = 4'b0001;

  initial begin : driver
    repeat (3) @(posedge clk);
    #5;
    checkNow("R1 reset hold", cmdOneHot, illegalCmd, 16'h8000, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #5;
    checkNow("R1 first cycle after reset", cmdOneHot, illegalCmd, 16'h8000, 1'b0);

    drive("R11 wake from reset", 1, NOPC, 0, 13);
    drive("R3 deselect", 1, DESEL, 0, 0);
    drive("R3 nop", 1, NOPC, 1, 0);
    drive("R4 mode load", 1, MRS, 0, 1);
    drive("R4 activate", 1, ACT, 0, 2);
    drive("R5 read", 1, RD, 0, 3);
    drive("R5 read auto-pre", 1, RD, 1, 4);
    drive("R5 write", 1, WR, 0, 5);
    drive("R5 write auto-pre", 1, WR, 1, 6);
    drive("R6 precharge one", 1, PRE, 0, 7);
    drive("R6 precharge all", 1, PRE, 1, 8);
    drive("R7 burst stop", 1, BST, 0, 9);
    drive("R8 auto refresh", 1, REF, 0, 10);
    drive("R9 self refresh entry", 0, REF, 0, 11);
    drive("R12 hold activate", 0, ACT, 0, 15);
    drive("R12 hold read", 0, RD, 1, 15);
    drive("R11 wake", 1, NOPC, 0, 13);
    drive("R10 sleep entry", 0, DESEL, 0, 12);
    drive("R11 suspend exit read", 1, RD, 0, 14);
    drive("R13 illegal write on fall", 0, WR, 0, -1);
    drive("R12 hold nop", 0, NOPC, 0, 15);
    drive("R11 wake deselect", 1, DESEL, 0, 13);
    drive("R13 illegal mode load on fall", 0, MRS, 0, -1);
    drive("R11 suspend exit activate", 1, ACT, 0, 14);
    drive("R3 nop after exit", 1, NOPC, 0, 0);
    drive("R4 activate a10 ignored", 1, ACT, 1, 2);
    drive("R10 sleep entry nop", 0, NOPC, 1, 12);
    drive("R2 wake", 1, NOPC, 0, 13);

    @(negedge clk);
    cke = 1'b1;
    {csN, rasN, casN, weN} = NOPC;
    while (expCmdQ.size() != 0) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule